// File: doc/BRIEF.md
# Stack Address Window Decoder

This block sits beside one host-bridge stack and decides which of four address windows an incoming 64-bit system address belongs to. The four windows are two memory-mapped I/O ranges, a window onto the bridge's own register file, and an interrupt-source window. Software programs each window over a simple 64-bit register bus. It sets a base register for every window and a mask register for each I/O range, and then turns windows on through an enable register. For every address presented on the decode port, the block reports whether it hits an enabled window, which window that is, and the byte offset of the address inside it.

A window's position and size are taken into a mapped snapshot only when the enable register is written. An enable bit that turns on captures the window's current geometry. An enable bit that stays on keeps the geometry it already has. An enable bit that turns off unmaps the window. A small two-state machine handles this. `ST_RUN` is the normal decoding state. `ST_REMAP` is the one cycle after any enable-register write: the snapshot is refreshed and no hit is reported. The transitions are: `ST_RUN` to `ST_REMAP` on an enable write, `ST_REMAP` to `ST_REMAP` if another enable write arrives, and `ST_REMAP` to `ST_RUN` otherwise. Rewriting the base or mask of a window while it is enabled is reported as a one-cycle error pulse, and the register still accepts the write.

Top module: `stkwin_dec`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register reads zero, no window is mapped, hit_valid is 0, hit_offset is 0 and cfg_err is 0.
- R2: The enable register (index 0) stores only bits 63:60. Bit 63 enables I/O window 0, bit 62 enables I/O window 1, bit 61 enables the bridge-register window and bit 60 enables the interrupt window. Bits 59:0 always read 0.
- R3: The I/O window 0 base register (index 1), its mask register (index 2), the I/O window 1 base register (index 3) and its mask register (index 4) store bits 63:24 and read 0 in bits 23:0.
- R4: The bridge-register base (index 5) stores bits 63:22, and the interrupt base (index 6) stores bits 63:36. All other bits of these registers read 0.
- R5: rd_data combinationally returns the stored value of the register selected by rd_idx. A write takes effect at the clock edge where wr_en is high. Index 7 is unused: it always reads 0, and writes to it change nothing.
- R6: A window's decode base is its stored base register shifted right by 8. An I/O window's size is (bitwise NOT of its mask register) shifted right by 8, plus 1. An address hits when base <= addr and addr - base < size, and hit_offset is then addr - base. Without a hit, hit_offset is 0.
- R7: The bridge-register window is BRG_REG_COUNT*8 bytes long, and the interrupt window is INT_COUNT*65536 bytes long.
- R8: When several mapped windows contain the address, hit_win reports the first of: 0 (I/O 0), 1 (I/O 1), 2 (bridge registers), 3 (interrupt).
- R9: A write to a base or mask register whose window's enable bit is currently set raises cfg_err for exactly the cycle after the write edge, and the new value is still stored. Writes to other registers, or to windows that are not enabled, leave cfg_err low.
- R10: In the cycle after an enable-register write, hit_valid is 0. At the following edge, each window whose enable bit is set and that is not yet mapped captures its geometry from the current registers, and each window whose enable bit is clear becomes unmapped.
- R11: A window that stays enabled across enable writes keeps its captured geometry. Rewriting its base or mask does not move the decode until the window is disabled and enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index for the write |
| wr_data | input | 64 | Write data |
| rd_idx | input | 3 | Register index for the read |
| rd_data | output | 64 | Stored value of the selected register |
| cfg_err | output | 1 | Pulse: an enabled window's base or mask was rewritten |
| addr_i | input | 64 | System address to decode |
| hit_valid | output | 1 | Address lies inside a mapped window |
| hit_win | output | 2 | Winning window (0 I/O 0, 1 I/O 1, 2 bridge registers, 3 interrupt) |
| hit_offset | output | 64 | Byte offset of addr_i inside the winning window |

## Verification
The decode is tried with addresses one below each window's base, at the base, at the last byte, and one past the end. These points separate off-by-one errors in the lower and upper bounds and mistakes in the shifted-base and inverted-mask size arithmetic. Overlapping I/O windows with different masks separate a correct priority from a reversed one. Enabling, re-enabling with a moved base, and disabling windows tell snapshot capture apart from live decoding, and they expose any hit leaking through the remap cycle. A long stretch of random register writes, including writes to enabled windows and to the unused index, mixed with addresses aimed at window edges, is compared against a behavioural model on every clock.

// File: rtl/stkwin_pkg.sv
package stkwin_pkg;
    localparam int DW     = 64;
    localparam int NWIN   = 4;
    localparam int IDX_W  = 3;
    localparam int NREG   = 1 << IDX_W;
    localparam int WSEL_W = $clog2(NWIN);

    typedef enum logic [IDX_W-1:0] {
        IX_ENABLE   = 3'd0,
        IX_M0_BASE  = 3'd1,
        IX_M0_MASK  = 3'd2,
        IX_M1_BASE  = 3'd3,
        IX_M1_MASK  = 3'd4,
        IX_BRG_BASE = 3'd5,
        IX_INT_BASE = 3'd6,
        IX_SPARE    = 3'd7
    } reg_idx_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_REMAP = 1'b1
    } map_state_e;

    typedef struct packed {
        logic [DW-1:0] base;
        logic [DW-1:0] size;
    } win_geom_t;

    localparam logic [DW-1:0] KEEP_ENABLE = 64'hF000_0000_0000_0000;
    localparam logic [DW-1:0] KEEP_MMIO   = 64'hFFFF_FFFF_FF00_0000;
    localparam logic [DW-1:0] KEEP_BRG    = 64'hFFFF_FFFF_FFC0_0000;
    localparam logic [DW-1:0] KEEP_INT    = 64'hFFFF_FFF0_0000_0000;

    function automatic logic [DW-1:0] keep_mask(input logic [IDX_W-1:0] idx);
        unique case (idx)
            IX_ENABLE:                                     keep_mask = KEEP_ENABLE;
            IX_M0_BASE, IX_M0_MASK, IX_M1_BASE, IX_M1_MASK: keep_mask = KEEP_MMIO;
            IX_BRG_BASE:                                   keep_mask = KEEP_BRG;
            IX_INT_BASE:                                   keep_mask = KEEP_INT;
            default:                                       keep_mask = '0;
        endcase
    endfunction

    // {guarded, window number}: which window a base/mask register belongs to
    function automatic logic [WSEL_W:0] guard_of(input logic [IDX_W-1:0] idx);
        unique case (idx)
            IX_M0_BASE, IX_M0_MASK: guard_of = {1'b1, 2'd0};
            IX_M1_BASE, IX_M1_MASK: guard_of = {1'b1, 2'd1};
            IX_BRG_BASE:            guard_of = {1'b1, 2'd2};
            IX_INT_BASE:            guard_of = {1'b1, 2'd3};
            default:                guard_of = '0;
        endcase
    endfunction
endpackage

// File: rtl/stkwin_regs.sv
module stkwin_regs
    import stkwin_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [DW-1:0]             wr_data,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [DW-1:0]             rd_data,
    output logic [NREG-1:0][DW-1:0]   regs_o,
    output logic [NWIN-1:0]           win_en_o,
    output logic                      err_o
);
    logic [NREG-1:0][DW-1:0] regs_q;
    logic                    err_q;
    logic [WSEL_W:0]         guard;

    assign guard = guard_of(wr_idx);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= wr_en && guard[WSEL_W] && win_en_o[guard[WSEL_W-1:0]];
            if (wr_en) begin
                regs_q[wr_idx] <= wr_data & keep_mask(wr_idx);
            end
        end
    end

    for (genvar k = 0; k < NWIN; k++) begin : g_en
        assign win_en_o[k] = regs_q[IX_ENABLE][DW-1-k];
    end

    assign rd_data = regs_q[rd_idx];
    assign regs_o  = regs_q;
    assign err_o   = err_q;
endmodule

// File: rtl/stkwin_cmp.sv
module stkwin_cmp
    import stkwin_pkg::*;
(
    input  logic [DW-1:0] addr,
    input  win_geom_t     geom,
    input  logic          mapped,
    output logic          hit,
    output logic [DW-1:0] offset
);
    logic [DW-1:0] delta;

    assign delta  = addr - geom.base;
    assign hit    = mapped && (addr >= geom.base) && (delta < geom.size);
    assign offset = delta;
endmodule

// File: rtl/stkwin_dec.sv
module stkwin_dec
    import stkwin_pkg::*;
#(
    parameter int BRG_REG_COUNT = 2048,
    parameter int INT_COUNT     = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DW-1:0]     rd_data,
    output logic              cfg_err,
    input  logic [DW-1:0]     addr_i,
    output logic              hit_valid,
    output logic [WSEL_W-1:0] hit_win,
    output logic [DW-1:0]     hit_offset
);
    localparam logic [DW-1:0] BRG_SIZE = DW'(BRG_REG_COUNT) << 3;
    localparam logic [DW-1:0] INT_SIZE = DW'(INT_COUNT) << 16;

    map_state_e              state_q, state_d;
    logic [NREG-1:0][DW-1:0] regs;
    logic [NWIN-1:0]         win_en;
    logic [NWIN-1:0]         mapped_q;
    win_geom_t [NWIN-1:0]    geom_q;
    win_geom_t [NWIN-1:0]    cand;
    logic [NWIN-1:0]         w_hit;
    logic [NWIN-1:0][DW-1:0] w_off;
    logic                    en_write;

    stkwin_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .regs_o   (regs),
        .win_en_o (win_en),
        .err_o    (cfg_err)
    );

    assign en_write = wr_en && (wr_idx == IX_ENABLE);

    // candidate geometry from the live registers
    for (genvar k = 0; k < NWIN; k++) begin : g_cand
        if (k < 2) begin : g_mmio
            assign cand[k].base = regs[IX_M0_BASE + 2*k] >> 8;
            assign cand[k].size = ((~regs[IX_M0_MASK + 2*k]) >> 8) + DW'(1);
        end else if (k == 2) begin : g_brg
            assign cand[k].base = regs[IX_BRG_BASE] >> 8;
            assign cand[k].size = BRG_SIZE;
        end else begin : g_int
            assign cand[k].base = regs[IX_INT_BASE] >> 8;
            assign cand[k].size = INT_SIZE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (en_write) state_d = ST_REMAP;
            ST_REMAP: state_d = en_write ? ST_REMAP : ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // snapshot refresh during the remap cycle
    for (genvar k = 0; k < NWIN; k++) begin : g_snap
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mapped_q[k] <= 1'b0;
                geom_q[k]   <= '0;
            end else if (state_q == ST_REMAP) begin
                if (!win_en[k]) begin
                    mapped_q[k] <= 1'b0;
                end else if (!mapped_q[k]) begin
                    mapped_q[k] <= 1'b1;
                    geom_q[k]   <= cand[k];
                end
            end
        end

        stkwin_cmp u_cmp (
            .addr   (addr_i),
            .geom   (geom_q[k]),
            .mapped (mapped_q[k]),
            .hit    (w_hit[k]),
            .offset (w_off[k])
        );
    end

    // outputs: fixed priority, blanked while remapping
    always_comb begin
        hit_valid  = 1'b0;
        hit_win    = '0;
        hit_offset = '0;
        unique case (state_q)
            ST_RUN: begin
                for (int k = NWIN - 1; k >= 0; k--) begin
                    if (w_hit[k]) begin
                        hit_valid  = 1'b1;
                        hit_win    = WSEL_W'(k);
                        hit_offset = w_off[k];
                    end
                end
            end
            ST_REMAP: hit_valid = 1'b0;
            default:  hit_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/stkwin_chk.sv
module stkwin_chk
    import stkwin_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [DW-1:0]     rd_data,
    input logic              cfg_err,
    input logic              hit_valid,
    input logic [WSEL_W-1:0] hit_win,
    input logic [NWIN-1:0]   mapped_q
);
    // R10
    remap_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IX_ENABLE) |=> !hit_valid);

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(wr_en));

    // R8
    hit_mapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> mapped_q[hit_win]);

    // R2
    enable_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IX_ENABLE) |-> (rd_data[DW-5:0] == '0));

    // R5
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IX_SPARE) |-> (rd_data == '0));
endmodule

bind stkwin_dec stkwin_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .cfg_err   (cfg_err),
    .hit_valid (hit_valid),
    .hit_win   (hit_win),
    .mapped_q  (mapped_q)
);

// File: tb/stkwin_dec_tb.sv
`timescale 1ns/1ps
module stkwin_dec_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BRG_N      = 2048;
    localparam int INT_N      = 4096;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        cfg_err;
    logic [63:0] addr_i = '0;
    logic        hit_valid;
    logic [1:0]  hit_win;
    logic [63:0] hit_offset;

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    bit    started = 0;
    bit    done = 0;
    string tag = "R1 reset";

    stkwin_dec #(.BRG_REG_COUNT(BRG_N), .INT_COUNT(INT_N)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .cfg_err(cfg_err), .addr_i(addr_i), .hit_valid(hit_valid),
        .hit_win(hit_win), .hit_offset(hit_offset)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference model ----------------
    logic [63:0] m_reg  [8];
    bit          m_map  [4];
    logic [63:0] m_base [4];
    logic [63:0] m_size [4];
    bit          m_remap;
    bit          m_err;

    function automatic logic [63:0] ref_keep(int idx, logic [63:0] d);
        if (idx == 0)      return d & 64'hF000_0000_0000_0000;
        else if (idx <= 4) return d & 64'hFFFF_FFFF_FF00_0000;
        else if (idx == 5) return d & 64'hFFFF_FFFF_FFC0_0000;
        else if (idx == 6) return d & 64'hFFFF_FFF0_0000_0000;
        return 64'd0;
    endfunction

    function automatic int ref_win(int idx);
        if (idx == 1 || idx == 2) return 0;
        if (idx == 3 || idx == 4) return 1;
        if (idx == 5) return 2;
        if (idx == 6) return 3;
        return -1;
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_reg[i] = '0;
            for (int k = 0; k < 4; k++) begin
                m_map[k] = 0; m_base[k] = '0; m_size[k] = '0;
            end
            m_remap = 0;
            m_err   = 0;
        end else begin
            int w;
            w = ref_win(int'(wr_idx));
            m_err = wr_en && (w >= 0) && m_reg[0][63-w];
            if (m_remap) begin
                for (int k = 0; k < 4; k++) begin
                    if (!m_reg[0][63-k]) m_map[k] = 0;
                    else if (!m_map[k]) begin
                        m_map[k] = 1;
                        case (k)
                            0: begin m_base[k] = m_reg[1] >> 8; m_size[k] = ((~m_reg[2]) >> 8) + 1; end
                            1: begin m_base[k] = m_reg[3] >> 8; m_size[k] = ((~m_reg[4]) >> 8) + 1; end
                            2: begin m_base[k] = m_reg[5] >> 8; m_size[k] = 64'(BRG_N) * 64'd8; end
                            default: begin m_base[k] = m_reg[6] >> 8; m_size[k] = 64'(INT_N) * 64'd65536; end
                        endcase
                    end
                end
                m_remap = 0;
            end
            if (wr_en) begin
                m_reg[wr_idx] = ref_keep(int'(wr_idx), wr_data);
                if (wr_idx == 3'd0) m_remap = 1;
            end
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%h expected=%h", req, tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (started && !done) begin
            bit          e_hv;
            logic [1:0]  e_hw;
            logic [63:0] e_off;
            e_hv = 0; e_hw = 0; e_off = 0;
            if (!m_remap) begin
                for (int k = 0; k < 4; k++) begin
                    if (!e_hv && m_map[k] && addr_i >= m_base[k] && (addr_i - m_base[k]) < m_size[k]) begin
                        e_hv = 1; e_hw = 2'(k); e_off = addr_i - m_base[k];
                    end
                end
            end
            check("R2/R3/R4/R5 rd_data", rd_data, m_reg[rd_idx]);
            check("R9 cfg_err", {63'd0, cfg_err}, {63'd0, m_err});
            check("R6/R7/R10/R11 hit_valid", {63'd0, hit_valid}, {63'd0, e_hv});
            check("R8 hit_win", {62'd0, hit_win}, {62'd0, e_hw});
            check("R6 hit_offset", hit_offset, e_off);
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(logic [2:0] idx, logic [63:0] d);
        step();
        wr_en = 1; wr_idx = idx; wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic probe(logic [63:0] a);
        step();
        addr_i = a;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog [%s] actual=%0d expected<=%0d", tag, cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        tag = "R1 reset state";
        for (int i = 0; i < 8; i++) begin step(); rd_idx = 3'(i); end
        probe(64'd0);

        tag = "R2 R3 R4 R5 truncation";
        for (int i = 1; i < 8; i++) begin
            wr(3'(i), '1);
            rd_idx = 3'(i);
            step();
        end
        for (int i = 1; i < 7; i++) wr(3'(i), '0);

        tag = "R6 R7 MMIO0 bounds";
        wr(3'd1, 64'h0000_1000_0000_0000);       // base 0x10_0000_0000
        wr(3'd2, 64'hFFFF_FFFF_FF00_0000);       // size 0x10000
        rd_idx = 3'd0;
        wr(3'd0, 64'h8000_0000_0000_0000);
        probe(64'h0000_0010_0000_0000);
        probe(64'h0000_000F_FFFF_FFFF);
        probe(64'h0000_0010_0000_FFFF);
        probe(64'h0000_0010_0001_0000);

        tag = "R8 overlap priority";
        wr(3'd3, 64'h0000_1000_0000_0000);
        wr(3'd4, 64'hFFFF_FFFF_F000_0000);       // size 0x100000
        wr(3'd5, 64'h0000_2000_0000_0000);
        wr(3'd6, 64'h0000_0030_0000_0000);
        wr(3'd0, 64'hF000_0000_0000_0000);
        probe(64'h0000_0010_0000_0010);
        probe(64'h0000_0010_0001_0000);
        probe(64'h0000_0010_000F_FFFF);
        tag = "R7 bridge and interrupt sizes";
        probe(64'h0000_0020_0000_3FFF);
        probe(64'h0000_0020_0000_4000);
        probe(64'h0000_0000_3000_0000);
        probe(64'h0000_0000_3FFF_FFFF);
        probe(64'h0000_0000_4000_0000);

        tag = "R9 R11 rewrite enabled base";
        wr(3'd1, 64'h0000_5000_0000_0000);
        rd_idx = 3'd1;
        probe(64'h0000_0010_0000_0004);
        wr(3'd7, 64'hFFFF);
        tag = "R10 disable then re-enable";
        wr(3'd0, 64'h7000_0000_0000_0000);
        probe(64'h0000_0010_0000_0004);
        wr(3'd0, 64'hF000_0000_0000_0000);
        probe(64'h0000_0050_0000_0004);
        probe(64'h0000_0050_0000_0000);

        tag = "R6 R8 R9 R10 R11 random mix";
        for (int n = 0; n < 3000; n++) begin
            int k;
            step();
            wr_en = ($urandom % 6) == 0;
            wr_idx = 3'($urandom % 8);
            wr_data = {$urandom, $urandom};
            if (wr_idx == 3'd2 || wr_idx == 3'd4) wr_data[63:40] = '1;
            rd_idx = 3'($urandom % 8);
            k = $urandom % 4;
            case ($urandom % 5)
                0: addr_i = m_base[k] - 1;
                1: addr_i = m_base[k];
                2: addr_i = m_base[k] + m_size[k] - 1;
                3: addr_i = m_base[k] + m_size[k];
                default: addr_i = m_base[k] + 64'($urandom % 65536);
            endcase
        end
        step();
        wr_en = 0;
        repeat (3) step();
        finish_run();
    end
endmodule